// File: doc/BRIEF.md
# Host bus request/acknowledge adapter

This block sits between an APB host port and an internal register or decode fabric. The fabric speaks a simpler protocol. It takes a request flag, a read enable or a write enable, separate read and write byte addresses, write data and active-high byte enables. It answers with a one-cycle read acknowledge that carries data and an error flag, or a one-cycle write acknowledge that carries an error flag.

When an APB access phase is seen, the adapter launches one request and holds every request field frozen until the acknowledge for that direction arrives. It captures the response in that same cycle. On the next cycle it drops the request and completes the host transfer with a single-cycle PREADY. PSLVERR reflects the captured error flag. Only one transfer is in flight at any time, so responses come back in request order.

A parameter selects whether the host strobes drive the write byte enables, or whether the byte enables are tied to all ones for hosts that have no strobes.

Top module: `hostreq_adapter`

## Requirements
- R1: During and right after a synchronous active-low reset, `req_vld`, `pready`, `pslverr` and `prdata` are all zero.
- R2: When `psel` and `penable` are both high at a clock edge while the adapter is idle, `req_vld` is high from the next cycle. Exactly one of `req_wr` and `req_rd` is high: `req_wr` when `pwrite` was 1, and `req_rd` when `pwrite` was 0.
- R3: A write presents `paddr` on `wr_addr` and drives `rd_addr` to zero. A read presents `paddr` on `rd_addr` and drives `wr_addr` to zero. All request outputs stay unchanged from launch until the acknowledge is taken.
- R4: A write drives `pwdata` on `wr_data` and `pstrb` on `wr_be`, where bit i enables byte i. A read drives `wr_data` to zero and `wr_be` to all ones.
- R5: An acknowledge that matches the request direction, seen at a clock edge, drops `req_vld` in the next cycle. `pready` is high in that same next cycle, for exactly one cycle.
- R6: On a read, `prdata` in the `pready` cycle equals the `rd_data` that was present with `rd_ack`. A write leaves `prdata` unchanged.
- R7: `pslverr` is high in the `pready` cycle exactly when the error flag of the matching acknowledge was high. At all other times it is low.
- R8: An acknowledge for the other direction, or any acknowledge while no request is open, has no effect on `req_vld`, `pready` or the request fields.
- R9: No new request is launched while one is open or during the `pready` cycle. A further request needs a fresh access phase.
- R10: With parameter `USE_STRB` set to 0, `wr_be` is all ones for writes as well as reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| psel | input | 1 | APB select |
| penable | input | 1 | APB enable (access phase) |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | AW | APB byte address |
| pwdata | input | DW | APB write data |
| pstrb | input | DW/8 | APB write strobes |
| prdata | output | DW | APB read data |
| pready | output | 1 | APB transfer complete |
| pslverr | output | 1 | APB error response |
| req_vld | output | 1 | Internal request open |
| req_wr | output | 1 | Request is a write |
| req_rd | output | 1 | Request is a read |
| wr_addr | output | AW | Write byte address |
| rd_addr | output | AW | Read byte address |
| wr_data | output | DW | Write data |
| wr_be | output | DW/8 | Write byte enables, active high |
| rd_ack | input | 1 | Read acknowledge pulse |
| rd_err | input | 1 | Read error, qualified by rd_ack |
| rd_data | input | DW | Read data, qualified by rd_ack |
| wr_ack | input | 1 | Write acknowledge pulse |
| wr_err | input | 1 | Write error, qualified by wr_ack |

## Verification
The bench builds the adapter with a 4-bit address and a 16-bit data path, which gives two byte strobes. It builds one instance with `USE_STRB` at 1 and a second instance with it at 0. That small size lets it sweep every address and every strobe pattern for writes, and every address for reads. Each transfer is also crossed with acknowledge latencies of 0 to 3 cycles and with both error values. During the waits, a stray acknowledge for the wrong direction is injected, and acknowledges are also pulsed while the adapter is idle.

// File: rtl/hra_pkg.sv
// Shared definitions for the host request adapter.
package hra_pkg;
    // Direction of an internal request
    typedef enum logic {
        DIR_RD = 1'b0,
        DIR_WR = 1'b1
    } hra_dir_e;
endpackage

// File: rtl/hra_req_hold.sv
// Request launcher and holder.
// Registers the request fields when a transfer is launched and freezes them
// until the matching acknowledge is taken.
// Assumes launch is only raised while no request is open.
module hra_req_hold
    import hra_pkg::*;
#(
    parameter int AW       = 4,
    parameter int DW       = 16,
    parameter bit USE_STRB = 1'b1,
    localparam int SW      = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [SW-1:0] pstrb,
    input  logic          ack_hit,
    output logic          req_vld,
    output logic          req_wr,
    output logic          req_rd,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] wr_data,
    output logic [SW-1:0] wr_be
);
    logic [SW-1:0] strb_src;
    hra_dir_e      dir;

    assign dir = hra_dir_e'(pwrite);

    // Pick the byte-enable source: the host strobes, or all ones
    generate
        if (USE_STRB) begin : g_strb
            assign strb_src = pstrb;
        end else begin : g_nostrb
            assign strb_src = '1;
        end
    endgenerate

    // Launch the request, hold its fields, and close it on the acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req_vld <= 1'b0;
            req_wr  <= 1'b0;
            req_rd  <= 1'b0;
            wr_addr <= '0;
            rd_addr <= '0;
            wr_data <= '0;
            wr_be   <= '0;
        end else if (launch) begin
            req_vld <= 1'b1;
            req_wr  <= (dir == DIR_WR);
            req_rd  <= (dir == DIR_RD);
            wr_addr <= (dir == DIR_WR) ? paddr : '0;
            rd_addr <= (dir == DIR_RD) ? paddr : '0;
            wr_data <= (dir == DIR_WR) ? pwdata : '0;
            wr_be   <= (dir == DIR_WR) ? strb_src : '1;
        end else if (ack_hit) begin
            req_vld <= 1'b0;
            req_wr  <= 1'b0;
            req_rd  <= 1'b0;
        end
    end

    // Fields do not move while the request waits for its acknowledge
    p_hold_stable_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !ack_hit) |=> (req_vld && $stable(wr_addr) && $stable(rd_addr)
                                   && $stable(wr_data) && $stable(wr_be)
                                   && $stable(req_wr) && $stable(req_rd)));

    // An open request carries exactly one direction
    p_one_dir_r2: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |-> ($countones({req_wr, req_rd}) == 1));

    // A read request presents all byte enables
    p_rd_be_ones_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && req_rd) |-> (&wr_be));
endmodule

// File: rtl/hra_rsp_cap.sv
// Response capture.
// Samples the read data and the error flag in the acknowledge cycle and
// presents them to the host with a one-cycle ready.
// Assumes ack_hit is a single-cycle pulse for an open request.
module hra_rsp_cap #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ack_hit,
    input  logic          hit_is_rd,
    input  logic          err_in,
    input  logic [DW-1:0] rd_data,
    output logic          pready,
    output logic          pslverr,
    output logic [DW-1:0] prdata
);
    // Register the completion, the error and the read data
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pready  <= 1'b0;
            pslverr <= 1'b0;
            prdata  <= '0;
        end else begin
            pready  <= ack_hit;
            pslverr <= ack_hit && err_in;
            if (ack_hit && hit_is_rd) begin
                prdata <= rd_data;
            end
        end
    end

    // The ready is a single-cycle pulse
    p_ready_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pready |=> !pready);

    // The error is shown only together with ready
    p_err_with_ready_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pslverr |-> pready);
endmodule

// File: rtl/hostreq_adapter.sv
// Host bus to request/acknowledge adapter (top).
// Turns an APB access phase into one held internal request, and turns the
// matching acknowledge into a one-cycle PREADY with PSLVERR.
// Assumes an APB host that keeps its signals steady through the access phase.
module hostreq_adapter #(
    parameter int AW       = 4,
    parameter int DW       = 16,
    parameter bit USE_STRB = 1'b1,
    localparam int SW      = DW / 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    input  logic [SW-1:0] pstrb,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          req_vld,
    output logic          req_wr,
    output logic          req_rd,
    output logic [AW-1:0] wr_addr,
    output logic [AW-1:0] rd_addr,
    output logic [DW-1:0] wr_data,
    output logic [SW-1:0] wr_be,
    input  logic          rd_ack,
    input  logic          rd_err,
    input  logic [DW-1:0] rd_data,
    input  logic          wr_ack,
    input  logic          wr_err
);
    logic launch;
    logic ack_hit;
    logic err_sel;

    // Start only on an access phase while idle and not completing
    assign launch  = psel && penable && !req_vld && !pready;
    // Take only the acknowledge that matches the open direction
    assign ack_hit = req_vld && ((req_rd && rd_ack) || (req_wr && wr_ack));
    // Route the error flag that belongs to the open direction
    assign err_sel = req_rd ? rd_err : wr_err;

    hra_req_hold #(
        .AW       (AW),
        .DW       (DW),
        .USE_STRB (USE_STRB)
    ) u_hold (
        .clk     (clk),
        .rst_n   (rst_n),
        .launch  (launch),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .pwdata  (pwdata),
        .pstrb   (pstrb),
        .ack_hit (ack_hit),
        .req_vld (req_vld),
        .req_wr  (req_wr),
        .req_rd  (req_rd),
        .wr_addr (wr_addr),
        .rd_addr (rd_addr),
        .wr_data (wr_data),
        .wr_be   (wr_be)
    );

    hra_rsp_cap #(
        .DW (DW)
    ) u_rsp (
        .clk       (clk),
        .rst_n     (rst_n),
        .ack_hit   (ack_hit),
        .hit_is_rd (req_rd),
        .err_in    (err_sel),
        .rd_data   (rd_data),
        .pready    (pready),
        .pslverr   (pslverr),
        .prdata    (prdata)
    );

    // An access phase seen while idle opens a request in the right direction
    p_launch_r2: assert property (@(posedge clk) disable iff (!rst_n)
        launch |=> (req_vld && (req_wr == $past(pwrite))));

    // A matching acknowledge closes the request and completes the host transfer
    p_ack_close_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ack_hit |=> (!req_vld && pready));

    // No request is open during the completion cycle
    p_idle_at_ready_r9: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> !req_vld);

    // An open request without a matching acknowledge stays open
    p_wait_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !ack_hit) |=> (req_vld && !pready));
endmodule

// File: tb/sim_hostreq_adapter.sv
// Self-checking bench: sweeps addresses, strobes, latencies and errors.
module sim_hostreq_adapter;
    localparam int AW = 4;
    localparam int DW = 16;
    localparam int SW = DW / 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [AW-1:0] paddr = '0;
    logic [DW-1:0] pwdata = '0;
    logic [SW-1:0] pstrb = '0;
    logic          rd_ack = 1'b0, rd_err = 1'b0, wr_ack = 1'b0, wr_err = 1'b0;
    logic [DW-1:0] rd_data = '0;

    logic [DW-1:0] prdata, prdata1, wr_data, wr_data1;
    logic          pready, pslverr, req_vld, req_wr, req_rd;
    logic          pready1, pslverr1, req_vld1, req_wr1, req_rd1;
    logic [AW-1:0] wr_addr, rd_addr, wr_addr1, rd_addr1;
    logic [SW-1:0] wr_be, wr_be1;

    int checks = 0;
    int errors = 0;
    logic [DW-1:0] exp_prdata = '0;

    always #2.5 clk = ~clk;

    hostreq_adapter #(.AW(AW), .DW(DW), .USE_STRB(1'b1)) u0 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .req_vld(req_vld), .req_wr(req_wr),
        .req_rd(req_rd), .wr_addr(wr_addr), .rd_addr(rd_addr), .wr_data(wr_data),
        .wr_be(wr_be), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .wr_ack(wr_ack), .wr_err(wr_err)
    );

    hostreq_adapter #(.AW(AW), .DW(DW), .USE_STRB(1'b0)) u1 (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .pstrb(pstrb), .prdata(prdata1),
        .pready(pready1), .pslverr(pslverr1), .req_vld(req_vld1), .req_wr(req_wr1),
        .req_rd(req_rd1), .wr_addr(wr_addr1), .rd_addr(rd_addr1), .wr_data(wr_data1),
        .wr_be(wr_be1), .rd_ack(rd_ack), .rd_err(rd_err), .rd_data(rd_data),
        .wr_ack(wr_ack), .wr_err(wr_err)
    );

    task automatic chk(input logic ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // One APB transfer with an inline responder of the given latency
    task automatic xfer(input logic wr, input logic [AW-1:0] a, input logic [DW-1:0] d,
                        input logic [SW-1:0] s, input int lat, input logic err);
        logic [DW-1:0] rdv;
        rdv = DW'(a) * 16'h0931 + 16'h5a00 + DW'(lat);
        @(negedge clk);
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d; pstrb = s;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        chk(req_vld == 1'b1, "R2 req_vld", req_vld, 1);
        chk(req_wr == wr && req_rd == !wr, "R2 dir", {req_wr, req_rd}, {wr, !wr});
        chk(wr_addr == (wr ? a : '0), "R3 wr_addr", wr_addr, wr ? a : 0);
        chk(rd_addr == (wr ? '0 : a), "R3 rd_addr", rd_addr, wr ? 0 : a);
        chk(wr_data == (wr ? d : '0), "R4 wr_data", wr_data, wr ? d : 0);
        chk(wr_be == (wr ? s : '1), "R4 wr_be", wr_be, wr ? s : 2'b11);
        chk(wr_be1 == '1, "R10 wr_be nostrb", wr_be1, 2'b11);
        for (int i = 0; i < lat; i++) begin
            // R8: stray acknowledge of the other direction on the first wait
            if (i == 0) begin
                if (wr) rd_ack = 1'b1; else wr_ack = 1'b1;
                rd_err = 1'b1; wr_err = 1'b1; rd_data = ~rdv;
            end
            @(negedge clk);
            rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0;
            chk(req_vld == 1'b1 && pready == 1'b0, "R8 wait", {req_vld, pready}, 2'b10);
            chk(wr_addr == (wr ? a : '0) && rd_addr == (wr ? '0 : a)
                && wr_data == (wr ? d : '0) && wr_be == (wr ? s : '1),
                "R3 hold", {wr_addr, rd_addr}, {(wr ? a : 4'h0), (wr ? 4'h0 : a)});
        end
        if (wr) begin wr_ack = 1'b1; wr_err = err; end
        else begin rd_ack = 1'b1; rd_err = err; rd_data = rdv; end
        @(negedge clk);
        rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0; rd_data = 16'hdead;
        if (!wr) exp_prdata = rdv;
        chk(req_vld == 1'b0, "R5 drop", req_vld, 0);
        chk(pready == 1'b1, "R5 ready", pready, 1);
        chk(pslverr == err, "R7 pslverr", pslverr, err);
        chk(prdata == exp_prdata, "R6 prdata", prdata, exp_prdata);
        psel = 1'b0; penable = 1'b0;
        @(negedge clk);
        chk(pready == 1'b0 && pslverr == 1'b0, "R5 one cycle", {pready, pslverr}, 0);
        chk(req_vld == 1'b0, "R9 no relaunch", req_vld, 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(req_vld == 0 && pready == 0 && pslverr == 0 && prdata == 0,
            "R1 reset", {req_vld, pready, pslverr}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_vld == 0 && pready == 0 && pslverr == 0 && prdata == 0,
            "R1 after reset", {req_vld, pready, pslverr}, 0);
        // R8: acknowledges with no open request
        rd_ack = 1'b1; wr_ack = 1'b1; rd_err = 1'b1; wr_err = 1'b1; rd_data = 16'hbeef;
        @(negedge clk);
        rd_ack = 1'b0; wr_ack = 1'b0; rd_err = 1'b0; wr_err = 1'b0;
        @(negedge clk);
        chk(req_vld == 0 && pready == 0 && pslverr == 0 && prdata == 0,
            "R8 idle ack", {req_vld, pready, pslverr}, 0);
        for (int a = 0; a < 16; a++) begin
            for (int lat = 0; lat < 4; lat++) begin
                for (int e = 0; e < 2; e++) begin
                    for (int s = 0; s < 4; s++) begin
                        xfer(1'b1, AW'(a), DW'(a * 16'h1111 ^ (s << 8) ^ lat), SW'(s), lat, e[0]);
                    end
                    xfer(1'b0, AW'(a), 16'h0, 2'b00, lat, e[0]);
                end
            end
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule